// File: doc/BRIEF.md
# Byte-Wide SPI Master with Programmable Bit Clock

This block drives a serial peripheral link as its master and moves one byte in each direction per transfer. A 16-bit divisor sets the rate of a baud counter that runs on the system clock. Each baud tick marks half of an SCK period, so SCK always runs at half the baud-tick rate. Two static inputs select the SCK idle level (`cpol`) and which SCK edge samples data (`cpha`). Together they give the four usual SPI timing modes.

The transmit byte enters through a valid/ready handshake. The block takes a byte on any clock where `tx_valid` and `tx_ready` are both high, then keeps `tx_ready` low until the whole frame has finished, slave-select release included. While `tx_ready` is low, the upstream source can hold or drop `tx_valid`. Any valid asserted during that time has no effect and starts no transfer. The received byte leaves on `rx_data` with a one-cycle `rx_done` strobe. The receive side has no back-pressure, so the consumer must capture the byte in the strobe cycle. `cpol`, `cpha` and `divisor` must stay unchanged while `tx_ready` is low.

Top module: `spi_byte_master`

## Requirements
- R1: Out of reset, `sck` equals `cpol`, `ss_n` is 1, `mosi` is 0, `tx_ready` is 1 and `rx_done` is 0.
- R2: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` reads 0 from the next cycle until the frame ends. A `tx_valid` seen while `tx_ready` is 0 starts no second frame and does not change the byte being sent.
- R3: Let L = `divisor`, or 2 when `divisor` is 0 or 1. A frame toggles `sck` exactly 16 times. Edge k (k = 1..16) falls on the k·L-th clock after the accepting edge.
- R4: Whenever `ss_n` is high, `sck` sits at the level of `cpol` (0 gives idle low, 1 gives idle high).
- R5: Both directions run most significant bit first. `rx_data` holds the eight `miso` samples in the order they were taken, the first sample in bit 7.
- R6: With `cpha` = 0, `mosi` carries bit 7 from the cycle after acceptance, before the first `sck` edge. `miso` is sampled on the odd (leading) edges, and `mosi` changes only on the even (trailing) edges 2 to 14.
- R7: With `cpha` = 1, `mosi` changes on the odd (leading) edges 1 to 15, and `miso` is sampled on the even (trailing) edges.
- R8: `rx_done` is high for exactly one clock per frame, starting 15·L clocks after acceptance when `cpha` = 0 and 16·L clocks after when `cpha` = 1. `rx_data` holds the received byte in that cycle and until the next strobe.
- R9: `ss_n` falls in the cycle after acceptance. It rises, together with `tx_ready`, 17·L clocks after acceptance, which is one half period after the last edge. Between two frames it stays high for at least one clock.
- R10: Between frames, `mosi` keeps the last bit it drove, which is bit 0 of the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| divisor | input | 16 | Half-period of SCK in system clocks (0 and 1 act as 2) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Block idle and able to take a byte |
| tx_data | input | 8 | Byte to transmit |
| rx_done | output | 1 | One-cycle strobe: received byte present |
| rx_data | output | 8 | Last received byte |
| sck | output | 1 | Serial clock to the slave |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
Faults in the baud counter or the edge counter show up at the ports within one frame: the `rx_done` strobe or the rise of `tx_ready` moves away from its exact cycle, the count of `sck` toggles differs from sixteen, or `sck` ends at the wrong level once `ss_n` rises. A mistake in edge parity or in the shift registers makes the bytes exchanged with a modelled slave wrong in at least one of the four modes. A fault in sequencer state shows as a second fall of `ss_n` inside a single transfer, or as `mosi` changing between frames.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_SHIFT = 2'd1,
    XS_TAIL  = 2'd2
  } xfer_state_t;

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  localparam logic [DIV_W-1:0] MIN_LIM = DIV_W'(2);

  logic [DIV_W-1:0] count_q;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit = (divisor < MIN_LIM) ? MIN_LIM : divisor;
  end

  assign tick = run && (count_q >= (limit - DIV_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (restart || !run || tick) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + DIV_W'(1);
    end
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int EDGES  = 16,
  parameter int EDGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en,
  input  logic              active,
  input  logic              cpol,
  input  logic              tick,
  output logic              sck,
  output logic              edge_fire,
  output logic [EDGE_W-1:0] edge_idx
);

  localparam logic [EDGE_W-1:0] LAST = EDGE_W'(EDGES);

  logic              sck_q;
  logic [EDGE_W-1:0] done_q;

  assign edge_fire = en && tick && (done_q < LAST);
  assign edge_idx  = done_q + EDGE_W'(1);
  assign sck       = active ? sck_q : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      done_q <= '0;
    end else if (start) begin
      sck_q  <= cpol;
      done_q <= '0;
    end else if (edge_fire) begin
      sck_q  <= ~sck_q;
      done_q <= edge_idx;
    end
  end

  // R3
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q <= LAST);

  // R3
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(sck_q));

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8,
  parameter int EDGES  = 16,
  parameter int EDGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              cpha,
  input  logic              edge_fire,
  input  logic [EDGE_W-1:0] edge_idx,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done
);

  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES);
  localparam logic [EDGE_W-1:0] PREV_EDGE = EDGE_W'(EDGES - 1);

  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic              mosi_q;
  logic              lead;
  logic              sample_ev;
  logic              drive_ev;
  logic              last_sample;
  logic [DATA_W-1:0] rx_next;

  assign lead        = edge_idx[0];
  assign sample_ev   = edge_fire && (lead ^ cpha);
  assign drive_ev    = edge_fire && !(lead ^ cpha) && (edge_idx != LAST_EDGE);
  assign last_sample = sample_ev && (edge_idx == (cpha ? LAST_EDGE : PREV_EDGE));
  assign rx_next     = {rx_sr[DATA_W-2:0], miso};
  assign mosi        = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr  <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      if (!cpha) begin
        mosi_q <= load_data[DATA_W-1];
        tx_sr  <= {load_data[DATA_W-2:0], 1'b0};
      end else begin
        tx_sr  <= load_data;
      end
    end else if (drive_ev) begin
      mosi_q <= tx_sr[DATA_W-1];
      tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr   <= '0;
      rx_data <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (load) begin
        rx_sr <= '0;
      end else if (sample_ev) begin
        rx_sr <= rx_next;
        if (last_sample) begin
          rx_data <= rx_next;
          rx_done <= 1'b1;
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !drive_ev) |=> $stable(mosi_q));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              ss_n,
  output logic              mosi,
  input  logic              miso
);

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES);

  xfer_state_t       state_q;
  logic              ss_n_q;
  logic              accept;
  logic              tick;
  logic              edge_fire;
  logic [EDGE_W-1:0] edge_idx;

  assign tx_ready = (state_q == XS_IDLE);
  assign accept   = tx_valid && tx_ready;
  assign ss_n     = ss_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      ss_n_q  <= 1'b1;
    end else begin
      case (state_q)
        XS_IDLE: if (accept) begin
          state_q <= XS_SHIFT;
          ss_n_q  <= 1'b0;
        end
        XS_SHIFT: if (edge_fire && (edge_idx == LAST_EDGE)) begin
          state_q <= XS_TAIL;
        end
        XS_TAIL: if (tick) begin
          state_q <= XS_IDLE;
          ss_n_q  <= 1'b1;
        end
        default: begin
          state_q <= XS_IDLE;
          ss_n_q  <= 1'b1;
        end
      endcase
    end
  end

  spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q != XS_IDLE),
    .restart (accept),
    .divisor (divisor),
    .tick    (tick)
  );

  spi_sck_div #(.EDGES(EDGES), .EDGE_W(EDGE_W)) u_sck (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .en        (state_q == XS_SHIFT),
    .active    (state_q != XS_IDLE),
    .cpol      (cpol),
    .tick      (tick),
    .sck       (sck),
    .edge_fire (edge_fire),
    .edge_idx  (edge_idx)
  );

  spi_shifter #(.DATA_W(DATA_W), .EDGES(EDGES), .EDGE_W(EDGE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (tx_data),
    .cpha      (cpha),
    .edge_fire (edge_fire),
    .edge_idx  (edge_idx),
    .miso      (miso),
    .mosi      (mosi),
    .rx_data   (rx_data),
    .rx_done   (rx_done)
  );

  // R9
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> ss_n);

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> (sck == cpol));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_ready);

endmodule

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic [15:0] divisor = 16'd2;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        miso = 1'b0;
  logic        tx_ready, rx_done, sck, ss_n, mosi;
  logic [7:0]  rx_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .divisor(divisor),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_done(rx_done), .rx_data(rx_data), .sck(sck), .ss_n(ss_n),
    .mosi(mosi), .miso(miso)
  );

  // behavioural slave
  logic [7:0] s_tx, s_rx, s_sh;
  int s_edges = 0;
  int ss_falls = 0;

  always @(negedge ss_n) begin
    ss_falls++;
    s_sh = s_tx;
    s_rx = 8'h00;
    s_edges = 0;
    if (!cpha) miso = s_sh[7];
  end

  always @(sck) begin
    if (rst_n === 1'b1 && ss_n === 1'b0) begin
      s_edges++;
      if ((sck != cpol) ^ cpha) begin
        s_rx = {s_rx[6:0], mosi};
      end else if (cpha) begin
        miso = s_sh[7];
        s_sh = {s_sh[6:0], 1'b0};
      end else begin
        s_sh = {s_sh[6:0], 1'b0};
        miso = s_sh[7];
      end
    end
  end

  int done_cnt = 0;
  int done_cyc = 0;
  logic [7:0] done_data;
  always @(negedge clk) begin
    if (rst_n && rx_done) begin
      done_cnt++;
      done_cyc = cyc;
      done_data = rx_data;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [7:0] m, input logic [7:0] s);
    int acc, rdy, lim, guard;
    string mreq;
    mreq = cpha ? "R7" : "R6";
    lim = (divisor < 2) ? 2 : int'(divisor);
    s_tx = s;
    done_cnt = 0;
    ss_falls = 0;
    @(negedge clk);
    tx_data = m;
    tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    // R2: keep valid one more cycle with a different byte; must be ignored
    check(tx_ready == 1'b0, "R2", "ready after accept", tx_ready, 0);
    check(ss_n == 1'b0, "R9", "ss_n after accept", ss_n, 0);
    if (!cpha) check(mosi == m[7], "R6", "mosi before first edge", mosi, m[7]);
    tx_data = 8'hFF;
    @(negedge clk);
    tx_valid = 1'b0;
    guard = 0;
    while (!tx_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    rdy = cyc;
    check(rdy == acc + 17 * lim, "R9", "ready/ss release cycle", rdy - acc, 17 * lim);
    check(ss_n == 1'b1, "R9", "ss_n at end", ss_n, 1);
    check(s_edges == 16, "R3", "sck edge count", s_edges, 16);
    check(sck == cpol, "R4", "sck idle level", sck, cpol);
    check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    check(done_cyc == acc + (cpha ? 16 : 15) * lim, "R8", "done cycle",
          done_cyc - acc, (cpha ? 16 : 15) * lim);
    check(done_data == s, mreq, "master received byte", done_data, s);
    check(rx_data == s, "R5", "rx_data held", rx_data, s);
    check(s_rx == m, mreq, "slave received byte", s_rx, m);
    check(mosi == m[0], "R10", "mosi holds last bit", mosi, m[0]);
    repeat (3) @(negedge clk);
    check(ss_falls == 1, "R2", "frames started", ss_falls, 1);
    check(mosi == m[0] && sck == cpol, "R10", "line state between frames",
          {sck, mosi}, {cpol, m[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sck == cpol && ss_n == 1'b1 && mosi == 1'b0, "R1", "lines in reset",
          {sck, ss_n, mosi}, {cpol, 2'b10});
    check(tx_ready == 1'b1 && rx_done == 1'b0, "R1", "handshake in reset",
          {tx_ready, rx_done}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(sck == 1'b0 && ss_n == 1'b1 && mosi == 1'b0 && tx_ready == 1'b1, "R1",
          "after reset release", {sck, ss_n, mosi, tx_ready}, 4'b0101);
    cpol = 1'b1;
    @(negedge clk);
    check(sck == 1'b1, "R4", "idle level follows cpol", sck, 1);
    for (int mode = 0; mode < 4; mode++) begin
      for (int di = 0; di < 5; di++) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] mb, sb;
          cpol = mode[1];
          cpha = mode[0];
          case (di)
            0: divisor = 16'd0;
            1: divisor = 16'd1;
            2: divisor = 16'd2;
            3: divisor = 16'd3;
            default: divisor = 16'd6;
          endcase
          mb = 8'((k * 37 + mode * 11 + di * 5 + 13) & 255);
          if (k == 0) mb = 8'h00;
          if (k == 1) mb = 8'hFF;
          sb = mb ^ 8'hA5 ^ 8'(k + di);
          run_xfer(mb, sb);
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule